// File: doc/BRIEF.md
# UART Receive Buffer and Interrupt Flag Unit

This unit sits between the serial engine of a UART channel and its register interface. The receiver delivers each completed frame as a one-cycle strobe with a data byte and two error bits, one for parity mismatch and one for a bad stop bit. The unit holds up to two received bytes in arrival order and presents the oldest at a read port. Each stored byte carries its own error tags, which move forward with it. Its parity and framing flags are raised only when the tagged byte reaches the read position, not when it is received. A byte with an error is still stored.

The unit also keeps flags for the transmit path: the hand-off of written data into the transmit shift register, and the end of a transmission. Software clears flags by writing a one to their bit positions. It sets an enable bit for each flag. It can pulse a software reset that clears every flag and empties the buffer. One interrupt request line combines all enabled flags.

Top module: `uart_rxbuf_flags`

## Requirements
- R1: The buffer holds at most two bytes and presents them in arrival order. A completed reception is stored only if an entry is free once any read in the same cycle has been applied.
- R2: If both entries are still held when a reception completes, the new byte is dropped, the buffer contents are unchanged, and the overrun flag (bit 4) is set.
- R3: A byte received with a parity error or a framing error is still stored. If it lands in an empty buffer, the parity flag (bit 5) or framing flag (bit 6) is set in the same cycle that the byte appears at the read port.
- R4: An errored byte that lands behind an unread byte raises no error flag on arrival. Its flag is set in the cycle where the read of the first byte moves it to the read port.
- R5: The parity and framing flags clear when a one is written to their bit, or when the byte at the read port carries that error and is read. The overrun flag clears only when a one is written to bit 4; reads leave it unchanged.
- R6: The one-byte-full flag (bit 2) sets when a byte is stored into an empty buffer. The two-bytes-full flag (bit 3) sets when a byte is stored while one byte is already held.
- R7: Any read of a non-empty buffer clears the two-bytes-full flag. A read that leaves the buffer empty clears the one-byte-full flag.
- R8: The transmit-empty flag (bit 0) sets on a transmit hand-off strobe and clears on a transmit data write. The write wins if both occur in the same cycle.
- R9: The transmit-end flag (bit 1) sets on a stop-bit-sent strobe only while the transmit-empty flag is 1. It clears when a one is written to bit 1.
- R10: The interrupt request is high exactly while some flag is 1 and its enable bit is 1. The flag vector is: bit 0 transmit empty, bit 1 transmit end, bit 2 one byte full, bit 3 two bytes full, bit 4 overrun, bit 5 parity error, bit 6 framing error.
- R11: A software reset pulse clears all flags and empties the buffer. The enable bits are kept.
- R12: A read of an empty buffer leaves the read port value and every flag unchanged. A read and a reception in the same cycle act as read first, then load.
- R13: When a flag's set event and a write-one-to-clear of that flag occur in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_reset | input | 1 | Software reset pulse: clears flags and buffer |
| rx_done | input | 1 | Receive shift register holds a completed frame |
| rx_data | input | DATA_W | Received byte |
| rx_perr | input | 1 | Parity mismatch for this frame |
| rx_ferr | input | 1 | Framing error for this frame |
| rd_en | input | 1 | Software read of the received data |
| rd_data | output | DATA_W | Byte at the read position |
| tx_wr | input | 1 | Software wrote transmit data |
| tx_load | input | 1 | Transmit data moved into the shift register |
| tx_stop | input | 1 | Stop bit has been sent |
| clr_wr | input | 1 | Write strobe for the flag clear mask |
| clr_mask | input | NFLAG | Write-one-to-clear mask |
| en_wr | input | 1 | Write strobe for the interrupt enables |
| en_data | input | NFLAG | New interrupt enable bits |
| flags | output | NFLAG | Flag vector |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench places a parity-errored byte behind a clean byte. A design that raised the flag on arrival would show bit 5 before the first read, and one that forgot the tag on shift would never show it. The bench also overfills the buffer and then drains it. This catches an overrun that corrupts stored data, an overrun flag that a read clears, and a one-byte-full flag that drops while a byte is still held. A read and a reception in the same cycle at one held byte must end with exactly the new byte presented. A design that loaded before reading would lose it or flag two bytes full. The bench also hits a clear write and an overrun in the same cycle, and a software reset with enables kept: a wrong priority loses the overrun, and a reset that wipes the enables silences the interrupt.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;

    localparam int NFLAG  = 7;
    localparam int F_TBE  = 0;
    localparam int F_TEND = 1;
    localparam int F_RB1  = 2;
    localparam int F_RB2  = 3;
    localparam int F_OE   = 4;
    localparam int F_PE   = 5;
    localparam int F_FE   = 6;

    typedef enum logic [1:0] {
        LVL_EMPTY = 2'd0,
        LVL_ONE   = 2'd1,
        LVL_TWO   = 2'd2
    } fill_t;

    typedef struct packed {
        logic pe;
        logic fe;
    } err_tag_t;

    typedef struct packed {
        logic     load_empty;
        logic     load_second;
        logic     overrun;
        logic     read_fire;
        logic     read_empties;
        logic     head_new;
        err_tag_t head_tag;
        err_tag_t read_tag;
    } rx_evt_t;

    function automatic fill_t fill_less(input fill_t f);
        case (f)
            LVL_TWO: return LVL_ONE;
            default: return LVL_EMPTY;
        endcase
    endfunction

    function automatic fill_t fill_more(input fill_t f);
        case (f)
            LVL_EMPTY: return LVL_ONE;
            default:   return LVL_TWO;
        endcase
    endfunction

endpackage

// File: rtl/uart_rx_store.sv
module uart_rx_store
    import uart_flag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_reset,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output fill_t             level,
    output rx_evt_t           evt
);

    localparam int ENTRIES = 2;

    logic [DATA_W-1:0] dat [ENTRIES];
    err_tag_t          tag [ENTRIES];
    fill_t             lvl;
    fill_t             after_rd;
    logic              read_fire;
    logic              loading;
    logic              shift;
    err_tag_t          in_tag;

    always_comb begin
        in_tag    = '{pe: rx_perr, fe: rx_ferr};
        read_fire = rd_en && (lvl != LVL_EMPTY);
        after_rd  = read_fire ? fill_less(lvl) : lvl;
        loading   = rx_done && (after_rd != LVL_TWO);
        shift     = read_fire && (lvl == LVL_TWO);

        evt.load_empty   = loading && (after_rd == LVL_EMPTY);
        evt.load_second  = loading && (after_rd == LVL_ONE);
        evt.overrun      = rx_done && (after_rd == LVL_TWO);
        evt.read_fire    = read_fire;
        evt.read_empties = read_fire && (lvl == LVL_ONE) && !loading;
        evt.head_new     = evt.load_empty || shift;
        evt.head_tag     = evt.load_empty ? in_tag : tag[1];
        evt.read_tag     = tag[0];
    end

    always_ff @(posedge clk) begin
        if (rst || sw_reset) begin
            lvl <= LVL_EMPTY;
            for (int i = 0; i < ENTRIES; i++) begin
                dat[i] <= '0;
                tag[i] <= '0;
            end
        end else begin
            if (shift) begin
                dat[0] <= dat[1];
                tag[0] <= tag[1];
            end
            if (loading) begin
                if (after_rd == LVL_EMPTY) begin
                    dat[0] <= rx_data;
                    tag[0] <= in_tag;
                end else begin
                    dat[1] <= rx_data;
                    tag[1] <= in_tag;
                end
            end
            lvl <= loading ? fill_more(after_rd) : after_rd;
        end
    end

    assign rd_data = dat[0];
    assign level   = lvl;

    AST_OVR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rx_done && lvl == LVL_TWO && !rd_en && !sw_reset) |=> (lvl == LVL_TWO && $stable(rd_data))); // R2

    AST_EMPTY_READ_STABLE: assert property (@(posedge clk) disable iff (rst)
        (rd_en && lvl == LVL_EMPTY && !rx_done && !sw_reset) |=> $stable(rd_data)); // R12

endmodule

// File: rtl/uart_flag_cell.sv
module uart_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic sw_reset,
    input  logic set,
    input  logic clr,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst || sw_reset) q <= 1'b0;
        else if (set)        q <= 1'b1;
        else if (clr)        q <= 1'b0;
    end

endmodule

// File: rtl/uart_rxbuf_flags.sv
module uart_rxbuf_flags
    import uart_flag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_reset,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tx_wr,
    input  logic              tx_load,
    input  logic              tx_stop,
    input  logic              clr_wr,
    input  logic [NFLAG-1:0]  clr_mask,
    input  logic              en_wr,
    input  logic [NFLAG-1:0]  en_data,
    output logic [NFLAG-1:0]  flags,
    output logic              irq
);

    fill_t            level;
    rx_evt_t          evt;
    logic [NFLAG-1:0] w1c;
    logic [NFLAG-1:0] f_set;
    logic [NFLAG-1:0] f_clr;
    logic [NFLAG-1:0] irq_en;

    uart_rx_store #(.DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .sw_reset (sw_reset),
        .rx_done  (rx_done),
        .rx_data  (rx_data),
        .rx_perr  (rx_perr),
        .rx_ferr  (rx_ferr),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .level    (level),
        .evt      (evt)
    );

    always_comb begin
        w1c = clr_wr ? clr_mask : '0;

        f_set[F_TBE]  = tx_load && !tx_wr;
        f_clr[F_TBE]  = tx_wr;
        f_set[F_TEND] = tx_stop && flags[F_TBE];
        f_clr[F_TEND] = w1c[F_TEND];
        f_set[F_RB1]  = evt.load_empty;
        f_clr[F_RB1]  = evt.read_empties;
        f_set[F_RB2]  = evt.load_second;
        f_clr[F_RB2]  = evt.read_fire;
        f_set[F_OE]   = evt.overrun;
        f_clr[F_OE]   = w1c[F_OE];
        f_set[F_PE]   = evt.head_new && evt.head_tag.pe;
        f_clr[F_PE]   = w1c[F_PE] || (evt.read_fire && evt.read_tag.pe);
        f_set[F_FE]   = evt.head_new && evt.head_tag.fe;
        f_clr[F_FE]   = w1c[F_FE] || (evt.read_fire && evt.read_tag.fe);
    end

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        uart_flag_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .sw_reset (sw_reset),
            .set      (f_set[g]),
            .clr      (f_clr[g]),
            .q        (flags[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)        irq_en <= '0;
        else if (en_wr) irq_en <= en_data;
    end

    assign irq = |(flags & irq_en);

    AST_OE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flags[F_OE] && !(clr_wr && clr_mask[F_OE]) && !sw_reset) |=> flags[F_OE]); // R5

    AST_PE_AT_HEAD: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[F_PE]) |-> (level != LVL_EMPTY)); // R3

    AST_SWRST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        sw_reset |=> (flags == '0 && level == LVL_EMPTY)); // R11

    AST_RB2_FULL: assert property (@(posedge clk) disable iff (rst)
        flags[F_RB2] |-> (level == LVL_TWO)); // R6

    AST_TEND_NEEDS_TBE: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[F_TEND]) |-> $past(flags[F_TBE])); // R9

endmodule

// File: tb/sim_uart_rxbuf_flags.sv
module sim_uart_rxbuf_flags;
    localparam int DW = 8;
    localparam int NF = 7;

    logic clk = 1'b0;
    logic rst, sw_reset, rx_done, rx_perr, rx_ferr, rd_en;
    logic tx_wr, tx_load, tx_stop, clr_wr, en_wr;
    logic [DW-1:0] rx_data, rd_data;
    logic [NF-1:0] clr_mask, en_data, flags;
    logic irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int cyc = 0;

    always #2 clk = ~clk;

    uart_rxbuf_flags #(.DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .sw_reset(sw_reset), .rx_done(rx_done),
        .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
        .rd_en(rd_en), .rd_data(rd_data), .tx_wr(tx_wr), .tx_load(tx_load),
        .tx_stop(tx_stop), .clr_wr(clr_wr), .clr_mask(clr_mask),
        .en_wr(en_wr), .en_data(en_data), .flags(flags), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            summary();
            $finish;
        end
    end

    task automatic idle();
        sw_reset = 0; rx_done = 0; rx_perr = 0; rx_ferr = 0; rd_en = 0;
        rx_data = 0; tx_wr = 0; tx_load = 0; tx_stop = 0; clr_wr = 0;
        clr_mask = 0; en_wr = 0; en_data = 0;
    endtask

    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic rx(input logic [DW-1:0] d, input bit pe, input bit fe);
        rx_done = 1; rx_data = d; rx_perr = pe; rx_ferr = fe;
        step();
    endtask

    task automatic rd();
        rd_en = 1;
        step();
    endtask

    task automatic w1c(input logic [NF-1:0] m);
        clr_wr = 1; clr_mask = m;
        step();
    endtask

    task automatic t_reset();
        chk("R11 reset flags", flags, 0);
        chk("R10 reset irq", irq, 0);
    endtask

    task automatic t_fifo_overrun();
        rx(8'hA1, 0, 0);
        chk("R6 one-full set", flags, 7'h04);
        chk("R1 head A1", rd_data, 8'hA1);
        rx(8'hB2, 0, 0);
        chk("R6 two-full set", flags, 7'h0C);
        chk("R1 order keeps A1", rd_data, 8'hA1);
        rx(8'hC3, 0, 0);
        chk("R2 overrun flag", flags, 7'h1C);
        chk("R2 contents kept", rd_data, 8'hA1);
        rd();
        chk("R7 read clears two-full", flags, 7'h14);
        chk("R1 second byte B2", rd_data, 8'hB2);
        rd();
        chk("R7 empty clears one-full, R5 OE kept", flags, 7'h10);
        rd();
        chk("R12 empty read data", rd_data, 8'hB2);
        chk("R12 empty read flags", flags, 7'h10);
        w1c(7'h10);
        chk("R5 OE w1c", flags, 0);
    endtask

    task automatic t_err_tags();
        rx(8'h11, 0, 0);
        rx(8'h22, 1, 0);
        chk("R4 no PE on arrival", flags, 7'h0C);
        rd();
        chk("R4 PE on move to head", flags, 7'h24);
        chk("R3 errored byte stored", rd_data, 8'h22);
        rd();
        chk("R5 read of errored byte clears PE", flags, 0);
        rx(8'h33, 0, 1);
        chk("R3 FE at head on load", flags, 7'h44);
        chk("R3 FE byte stored", rd_data, 8'h33);
        w1c(7'h40);
        chk("R5 FE w1c", flags, 7'h04);
        rd();
        chk("R7 drained", flags, 0);
    endtask

    task automatic t_same_cycle();
        rx(8'h44, 0, 0);
        rd_en = 1; rx_done = 1; rx_data = 8'h55;
        step();
        chk("R12 read-then-load data", rd_data, 8'h55);
        chk("R12 read-then-load flags", flags, 7'h04);
        rd();
        chk("R12 drained", flags, 0);
    endtask

    task automatic t_set_wins();
        rx(8'h01, 0, 0);
        rx(8'h02, 0, 0);
        rx_done = 1; rx_data = 8'h03; clr_wr = 1; clr_mask = 7'h10;
        step();
        chk("R13 overrun beats w1c", flags, 7'h1C);
        w1c(7'h10);
        rd();
        rd();
        chk("R13 cleanup", flags, 0);
    endtask

    task automatic t_tx();
        tx_load = 1; step();
        chk("R8 TBE set", flags, 7'h01);
        tx_stop = 1; step();
        chk("R9 TEND set", flags, 7'h03);
        tx_wr = 1; step();
        chk("R8 TBE cleared by write", flags, 7'h02);
        w1c(7'h02);
        tx_stop = 1; step();
        chk("R9 TEND needs TBE", flags, 0);
        tx_load = 1; tx_wr = 1; step();
        chk("R8 write wins", flags, 0);
    endtask

    task automatic t_irq();
        en_wr = 1; en_data = 7'h02; step();
        tx_load = 1; step();
        chk("R10 masked flag no irq", irq, 0);
        tx_stop = 1; step();
        chk("R10 enabled flag irq", irq, 1);
        w1c(7'h02);
        chk("R10 irq drops", irq, 0);
        tx_wr = 1; step();
    endtask

    task automatic t_swrst();
        rx(8'h0A, 0, 0);
        rx(8'h0B, 1, 0);
        tx_load = 1; step();
        chk("R11 pre-reset flags", flags, 7'h0D);
        sw_reset = 1; step();
        chk("R11 sw_reset flags", flags, 0);
        rx(8'h66, 0, 0);
        chk("R11 buffer emptied", flags, 7'h04);
        chk("R11 new head", rd_data, 8'h66);
        tx_load = 1; step();
        tx_stop = 1; step();
        chk("R11 enables kept", irq, 1);
    endtask

    initial begin
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        step();
        t_reset();
        t_fifo_overrun();
        t_err_tags();
        t_same_cycle();
        t_set_wins();
        t_tx();
        t_irq();
        t_swrst();
        done = 1'b1;
        summary();
        $finish;
    end
endmodule